// File: doc/BRIEF.md
# Boot Source Decision Controller

This block makes the reset-time choice between staying in the serial loader and starting the application. After reset it fetches four configuration bytes over a simple request/acknowledge read port: a marker byte at the start of program memory, the read-out protection byte, and a pair of option bytes that must be complements of each other. From these bytes it picks one of three policies. It can wait with no time limit for a host connection. It can wait for a limited window and then fall through to the application. It can skip the loader entirely.

A separate sync detector reports host synchronisation attempts on `sync_seen`, and a free-running millisecond source supplies `ms_tick`. The block ignores sync attempts during a short guard period after reset. When it reaches a decision it raises exactly one of `enter_loader` or `jump_app` and holds it until the next reset.

The controller is a single state machine with five states:
- `ST_FETCH`: the configuration bytes are being read.
- `ST_OPEN`: memory is blank and the block waits without a limit.
- `ST_WINDOW`: memory is programmed and the loader is allowed, so the block waits for a limited window.
- `ST_LOADER`: final state; the loader is entered.
- `ST_APP`: final state; the block jumps to the application.

The transitions are:
- **fetch-to-app**: from `ST_FETCH` when protection is set, or when memory is programmed and the option pair is wrong.
- **fetch-to-open**: from `ST_FETCH` when memory is blank.
- **fetch-to-window**: from `ST_FETCH` when memory is programmed and the pair is correct.
- **open-accept**: from `ST_OPEN` to `ST_LOADER`.
- **window-accept**: from `ST_WINDOW` to `ST_LOADER`.
- **window-expire**: from `ST_WINDOW` to `ST_APP`.

Top module: `boot_src_ctrl`

## Requirements
- R1: While reset is held and right after its release, `enter_loader` and `jump_app` are both 0, `rd_req` is 1 and `rd_addr` is 0x8000.
- R2: The block reads its configuration in this fixed order: 0x8000 (marker), 0x4800 (protection), 0x487E (option), 0x487F (option complement). Each address is held with `rd_req` high until a cycle with `rd_ack` high, and `rd_data` is taken in that cycle.
- R3: Memory counts as blank when the marker is neither 0x82 nor 0xAC. If protection is 0x00 and memory is blank, the block waits without limit: it decides nothing even after more than `WIN_MS` ticks, and an accepted sync then raises `enter_loader`.
- R4: If the marker is 0x82 or 0xAC, protection is 0x00 and the option pair reads 0x55 then 0xAA, an accepted sync raises `enter_loader`. This holds while fewer than `WIN_MS` ticks have been counted since reset, and also in the cycle where tick number `WIN_MS` arrives.
- R5: In the windowed case with no accepted sync, `jump_app` rises one cycle after the tick count reaches `WIN_MS`. A sync in the cycle after tick number `WIN_MS` is too late.
- R6: If memory is programmed, protection is 0x00 and the option pair is anything other than 0x55/0xAA, `jump_app` rises straight after the fetch, and later syncs are ignored.
- R7: A protection byte other than 0x00 causes `jump_app` straight after the fetch, whatever the marker and the option pair.
- R8: A sync is accepted only once at least `GUARD_MS` ticks have been counted since reset. An earlier sync has no effect.
- R9: At most one of `enter_loader` and `jump_app` is ever 1, and once one of them is 1 it stays 1 until reset.
- R10: `rd_req` is 0 once a decision output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | output | 1 | Configuration read request |
| rd_addr | output | 16 | Address of the requested byte |
| rd_ack | input | 1 | Read completes; `rd_data` valid this cycle |
| rd_data | input | 8 | Byte read |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sync_seen | input | 1 | One-cycle pulse when a host sync is detected |
| enter_loader | output | 1 | Latched decision: stay in the loader |
| jump_app | output | 1 | Latched decision: start the application |

## Verification
The assertions assume the following about the inputs:
- `rd_ack` arrives only while `rd_req` is high.
- `rd_ack` lasts a single cycle per byte.
- `ms_tick` and `sync_seen` are single-cycle pulses.

The checker's own tick counter relies on these assumptions to judge whether a sync came inside the guard period. The bench drives every acknowledge, tick and sync as a one-cycle pulse set on a falling edge. It acknowledges only after it has seen `rd_req` high with the expected address. It never asserts `rd_ack` after the fourth byte.

// File: rtl/boot_src_pkg.sv
package boot_src_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int NUM_CFG = 4;
    localparam int IDX_W   = $clog2(NUM_CFG);

    // marker values that mean "program memory holds an application"
    localparam logic [DATA_W-1:0] MARK_A    = 8'h82;
    localparam logic [DATA_W-1:0] MARK_B    = 8'hAC;
    // loader-enable key and its complement
    localparam logic [DATA_W-1:0] KEY_LO    = 8'h55;
    localparam logic [DATA_W-1:0] KEY_HI    = 8'hAA;
    localparam logic [DATA_W-1:0] PROT_OPEN = 8'h00;

    // configuration byte slots, in fetch order
    localparam int SLOT_MARK = 0;
    localparam int SLOT_PROT = 1;
    localparam int SLOT_OPT  = 2;
    localparam int SLOT_OPTN = 3;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPEN,
        ST_WINDOW,
        ST_LOADER,
        ST_APP
    } boot_st_e;

    function automatic logic [ADDR_W-1:0] cfg_addr(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(SLOT_MARK): cfg_addr = 16'h8000;
            IDX_W'(SLOT_PROT): cfg_addr = 16'h4800;
            IDX_W'(SLOT_OPT):  cfg_addr = 16'h487E;
            default:           cfg_addr = 16'h487F;
        endcase
    endfunction

endpackage

// File: rtl/boot_cfg_fetch.sv
module boot_cfg_fetch
    import boot_src_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd_ack,
    input  logic [DATA_W-1:0]                  rd_data,
    output logic                               rd_req,
    output logic [ADDR_W-1:0]                  rd_addr,
    output logic                               done,
    output logic [NUM_CFG-1:0][DATA_W-1:0]     cfg_bytes
);

    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic             take;

    assign take = rd_ack && !done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            done_q <= 1'b0;
        end else if (take) begin
            if (idx_q == IDX_W'(NUM_CFG - 1))
                done_q <= 1'b1;
            else
                idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_bytes[g] <= '0;
            else if (take && idx_q == IDX_W'(g))
                cfg_bytes[g] <= rd_data;
        end
    end

    assign rd_req  = !done_q;
    assign rd_addr = cfg_addr(idx_q);
    assign done    = done_q;

endmodule

// File: rtl/boot_ms_timer.sv
module boot_ms_timer #(
    parameter int GUARD_MS = 10,
    parameter int WIN_MS   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    output logic guard_done,
    output logic win_open
);

    localparam int CW = $clog2(WIN_MS + 1);
    localparam logic [CW-1:0] CNT_MAX   = CW'(WIN_MS);
    localparam logic [CW-1:0] CNT_GUARD = CW'(GUARD_MS);

    logic [CW-1:0] cnt_q;

    // saturating count of ticks since reset release
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ms_tick && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign guard_done = cnt_q >= CNT_GUARD;
    assign win_open   = cnt_q <  CNT_MAX;

endmodule

// File: rtl/boot_src_ctrl.sv
module boot_src_ctrl
    import boot_src_pkg::*;
#(
    parameter int GUARD_MS = 10,
    parameter int WIN_MS   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              ms_tick,
    input  logic              sync_seen,
    output logic              enter_loader,
    output logic              jump_app
);

    logic                           fetch_done;
    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_bytes;
    logic                           guard_done;
    logic                           win_open;

    boot_cfg_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .done      (fetch_done),
        .cfg_bytes (cfg_bytes)
    );

    boot_ms_timer #(
        .GUARD_MS (GUARD_MS),
        .WIN_MS   (WIN_MS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (ms_tick),
        .guard_done (guard_done),
        .win_open   (win_open)
    );

    logic blank_mem;
    logic prot_clear;
    logic key_ok;
    logic sync_ok;

    assign blank_mem  = (cfg_bytes[SLOT_MARK] != MARK_A) && (cfg_bytes[SLOT_MARK] != MARK_B);
    assign prot_clear = cfg_bytes[SLOT_PROT] == PROT_OPEN;
    assign key_ok     = (cfg_bytes[SLOT_OPT] == KEY_LO) && (cfg_bytes[SLOT_OPTN] == KEY_HI);
    assign sync_ok    = sync_seen && guard_done;

    boot_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FETCH: begin
                if (fetch_done) begin
                    if (!prot_clear)
                        st_d = ST_APP;       // fetch-to-app (protected)
                    else if (blank_mem)
                        st_d = ST_OPEN;      // fetch-to-open
                    else if (key_ok)
                        st_d = ST_WINDOW;    // fetch-to-window
                    else
                        st_d = ST_APP;       // fetch-to-app (no key)
                end
            end
            ST_OPEN: begin
                if (sync_ok)
                    st_d = ST_LOADER;        // open-accept
            end
            ST_WINDOW: begin
                if (sync_ok && win_open)
                    st_d = ST_LOADER;        // window-accept
                else if (!win_open)
                    st_d = ST_APP;           // window-expire
            end
            ST_LOADER: st_d = ST_LOADER;
            ST_APP:    st_d = ST_APP;
            default:   st_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_FETCH;
        else
            st_q <= st_d;
    end

    always_comb begin
        enter_loader = 1'b0;
        jump_app     = 1'b0;
        unique case (st_q)
            ST_LOADER: enter_loader = 1'b1;
            ST_APP:    jump_app     = 1'b1;
            default: begin
                enter_loader = 1'b0;
                jump_app     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/boot_src_ctrl_chk.sv
module boot_src_ctrl_chk #(
    parameter int GUARD_MS = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic [15:0] rd_addr,
    input logic        rd_ack,
    input logic        ms_tick,
    input logic        enter_loader,
    input logic        jump_app
);

    localparam int GW = $clog2(GUARD_MS + 1);
    localparam logic [GW-1:0] G_MAX = GW'(GUARD_MS);

    logic [GW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (ms_tick && seen_q != G_MAX)
            seen_q <= seen_q + 1'b1;
    end

    // R9
    decision_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_loader, jump_app}));

    // R9
    loader_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_loader |=> enter_loader);

    // R9
    app_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_app |=> jump_app);

    // R10
    req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_loader || jump_app) |-> !rd_req);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R8
    guard_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enter_loader) |-> (seen_q == G_MAX));

endmodule

bind boot_src_ctrl boot_src_ctrl_chk #(
    .GUARD_MS (GUARD_MS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_ack       (rd_ack),
    .ms_tick      (ms_tick),
    .enter_loader (enter_loader),
    .jump_app     (jump_app)
);

// File: tb/sim_boot_src_ctrl.sv
module sim_boot_src_ctrl;

    localparam int GUARD = 10;
    localparam int WIN   = 1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack;
    logic [7:0]  rd_data;
    logic        ms_tick;
    logic        sync_seen;
    logic        enter_loader;
    logic        jump_app;

    int checks   = 0;
    int failures = 0;

    // 8 ns period: 125 MHz
    always #4 clk = ~clk;

    boot_src_ctrl #(.GUARD_MS(GUARD), .WIN_MS(WIN)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_ack       (rd_ack),
        .rd_data      (rd_data),
        .ms_tick      (ms_tick),
        .sync_seen    (sync_seen),
        .enter_loader (enter_loader),
        .jump_app     (jump_app)
    );

    // {marker, protection, option, option complement, class}
    // class 0 = unlimited wait, 1 = windowed wait, 2 = application at once
    localparam logic [33:0] VEC [0:7] = '{
        {8'hFF, 8'h00, 8'h55, 8'hAA, 2'd0},
        {8'h82, 8'h00, 8'h55, 8'hAA, 2'd1},
        {8'hAC, 8'h00, 8'h55, 8'hAA, 2'd1},
        {8'h82, 8'h00, 8'h55, 8'hAB, 2'd2},
        {8'hAC, 8'h00, 8'h54, 8'hAA, 2'd2},
        {8'h82, 8'h01, 8'h55, 8'hAA, 2'd2},
        {8'h00, 8'h80, 8'h55, 8'hAA, 2'd2},
        {8'h83, 8'h00, 8'h00, 8'h00, 2'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        rd_ack    = 1'b0;
        rd_data   = 8'h00;
        ms_tick   = 1'b0;
        sync_seen = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset loader", {31'd0, enter_loader}, 0);
        rst_n = 1'b1;
    endtask

    task automatic serve(input logic [7:0] m, input logic [7:0] p, input logic [7:0] o, input logic [7:0] on);
        logic [7:0]  b [4];
        logic [15:0] a [4];
        b[0] = m; b[1] = p; b[2] = o; b[3] = on;
        a[0] = 16'h8000; a[1] = 16'h4800; a[2] = 16'h487E; a[3] = 16'h487F;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R2 req held", {31'd0, rd_req}, 1);
            check("R2 address order", {16'd0, rd_addr}, {16'd0, a[k]});
            rd_data = b[k];
            rd_ack  = 1'b1;
            @(negedge clk);
            rd_ack  = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic sync_pulse();
        @(negedge clk) sync_seen = 1'b1;
        @(negedge clk) sync_seen = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 directed: state right after release
        do_reset();
        check("R1 req after reset", {31'd0, rd_req}, 1);
        check("R1 addr after reset", {16'd0, rd_addr}, 32'h8000);
        check("R1 jump after reset", {31'd0, jump_app}, 0);

        // table walk: R3 R4 R6 R7 R10
        for (int v = 0; v < 8; v++) begin
            do_reset();
            serve(VEC[v][33:26], VEC[v][25:18], VEC[v][17:10], VEC[v][9:2]);
            if (VEC[v][1:0] == 2'd2) begin
                check("R6/R7 jump after fetch", {31'd0, jump_app}, 1);
                check("R10 req low", {31'd0, rd_req}, 0);
                ticks(GUARD);
                sync_pulse();
                check("R6 sync ignored loader", {31'd0, enter_loader}, 0);
                check("R9 jump held", {31'd0, jump_app}, 1);
            end else begin
                check("R3/R4 no decision yet", {30'd0, enter_loader, jump_app}, 0);
                ticks(GUARD);
                sync_pulse();
                check("R3/R4 sync enters loader", {31'd0, enter_loader}, 1);
                check("R10 req low", {31'd0, rd_req}, 0);
            end
        end

        // R8: early sync ignored, then accepted
        do_reset();
        serve(8'hFF, 8'h00, 8'h00, 8'h00);
        ticks(GUARD - 1);
        sync_pulse();
        check("R8 early sync ignored", {30'd0, enter_loader, jump_app}, 0);
        ticks(1);
        sync_pulse();
        check("R8 sync after guard", {31'd0, enter_loader}, 1);

        // R3: blank memory waits beyond the window
        do_reset();
        serve(8'h12, 8'h00, 8'h55, 8'hAA);
        ticks(WIN + 200);
        check("R3 still waiting", {30'd0, enter_loader, jump_app}, 0);
        sync_pulse();
        check("R3 late sync enters loader", {31'd0, enter_loader}, 1);

        // R5: window expires exactly
        do_reset();
        serve(8'h82, 8'h00, 8'h55, 8'hAA);
        ticks(WIN - 1);
        check("R5 open before last tick", {30'd0, enter_loader, jump_app}, 0);
        ticks(1);
        check("R5 not yet jumped", {31'd0, jump_app}, 0);
        @(negedge clk);
        check("R5 jump after window", {31'd0, jump_app}, 1);
        sync_pulse();
        check("R9 loader stays low", {31'd0, enter_loader}, 0);
        check("R9 jump stays high", {31'd0, jump_app}, 1);

        // R4: sync together with the last tick counts
        do_reset();
        serve(8'hAC, 8'h00, 8'h55, 8'hAA);
        ticks(WIN - 1);
        @(negedge clk);
        ms_tick   = 1'b1;
        sync_seen = 1'b1;
        @(negedge clk);
        ms_tick   = 1'b0;
        sync_seen = 1'b0;
        check("R4 last-tick sync", {30'd0, enter_loader, jump_app}, 2);

        // R5: sync one cycle after the last tick is too late
        do_reset();
        serve(8'h82, 8'h00, 8'h55, 8'hAA);
        ticks(WIN);
        sync_seen = 1'b1;
        @(negedge clk);
        sync_seen = 1'b0;
        check("R5 late sync rejected", {30'd0, enter_loader, jump_app}, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule